// File: doc/BRIEF.md
# Ripple-Through Marker-Bit FIFO

This block is a 16-entry, 4-bit elastic buffer between two systems that strobe data at unrelated rates. Storage is a chain of stages. Each stage holds one word and one occupancy marker. On every clock a vacant stage pulls the word from a full upstream neighbour, so written words fall toward the output end and vacancies rise toward the input end. The writer watches a ready flag at the input end. The reader watches a valid flag at the output end.

The writer loads a word with a rising edge on its shift-in strobe. The reader removes the word on a falling edge of its shift-out strobe. Both strobes are asynchronous to the block clock. Each passes through a two-flop synchronizer and then an edge detector. An output-disable control gates the shift-out strobe: while it is high no word can leave. If it drops while shift-out is already low, that drop acts as a removal edge. A master reset input clears all markers and leaves the stored words where they are. The output bus always shows the last stage's word. A separate enable output tells the pad logic when to drive that bus.

Top module: `rtfifo_top`

## Requirements
- R1: After reset (rst_n low), in_ready is 1, out_valid is 0 and dout_en is 1 while out_disable is 0.
- R2: A word is taken from din on a rising edge of shift_in while in_ready is 1. Holding shift_in high loads only that one word.
- R3: in_ready is 0 at the third clock edge after shift_in rises and 1 again at the fourth, when the word moves on into an empty second stage. With all 16 stages full, in_ready stays 0 and a shift_in edge adds nothing.
- R4: A word written into an empty FIFO makes out_valid rise at the 18th rising clock edge after shift_in goes high. That is 2 synchronizer flops, 1 edge detector and 15 stage moves.
- R5: A falling edge of shift_out while out_valid is 1 removes the word on dout. Words leave in the order they were loaded, with none lost or duplicated.
- R6: A shift_out edge while the FIFO is empty has no effect on a word loaded afterwards.
- R7: While out_disable is 1, shift_out edges remove nothing. out_valid stays 1 and dout holds its word.
- R8: If out_disable falls while shift_out is low, exactly one word is removed.
- R9: A one-cycle pulse on mreset leaves in_ready 1 and out_valid 0. The last stage's word still shows on dout, and later loads work normally.
- R10: A load edge and a removal edge in the same cycle are both honoured.
- R11: dout_en is the inverse of out_disable.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mreset | input | 1 | Master reset: clears occupancy, keeps stored words |
| shift_in | input | 1 | Load strobe, rising edge active |
| din | input | 4 | Word to load; held stable while shift_in is high |
| in_ready | output | 1 | First stage is empty |
| shift_out | input | 1 | Removal strobe, falling edge active |
| out_disable | input | 1 | Blocks removal and turns the output bus off |
| dout | output | 4 | Word in the last stage |
| out_valid | output | 1 | Last stage holds a word |
| dout_en | output | 1 | Drive enable for dout |

## Verification
The hardest condition to reach is a load and a removal landing in the same cycle. Both strobes go through synchronizers, and the FIFO must sit in a state where the input stage is empty and the output stage is full. The bench reaches this state by loading four words and waiting until they settle at the output end. It then toggles both strobes at the same falling clock edge, so the two equal-length synchronizer paths fire in the same cycle. The disable-release removal is reached the same way, from a single settled word with shift_out already held low.

// File: rtl/rtfifo_pkg.sv
// Package: shared defaults for the ripple-through FIFO.
// Assumes: consumers override through module parameters when needed.
package rtfifo_pkg;
    localparam int unsigned RT_DEPTH       = 16;
    localparam int unsigned RT_WIDTH       = 4;
    localparam int unsigned RT_SYNC_STAGES = 2;
endpackage

// File: rtl/rtfifo_edge_sync.sv
// Module: rtfifo_edge_sync
// Synchronizes an asynchronous strobe through STAGES flops and emits a
// one-cycle pulse on the selected edge (rising or falling).
// Assumes: STAGES >= 2; RESET_VAL chosen so reset creates no false edge.
module rtfifo_edge_sync #(
    parameter int unsigned STAGES    = rtfifo_pkg::RT_SYNC_STAGES,
    parameter bit          FALLING   = 1'b0,
    parameter bit          RESET_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic strobe_i,
    output logic edge_o
);
    localparam int unsigned TOP = STAGES - 1;

    logic [STAGES-1:0] sync_q;
    logic              prev_q;

    // Shift the strobe through the synchronizer and remember the last output.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_q <= {STAGES{RESET_VAL}};
            prev_q <= RESET_VAL;
        end else begin
            sync_q <= {sync_q[STAGES-2:0], strobe_i};
            prev_q <= sync_q[TOP];
        end
    end

    generate
        if (FALLING) begin : g_fall
            // Pulse when the synchronized level goes from high to low.
            always_comb edge_o = prev_q & ~sync_q[TOP];
        end else begin : g_rise
            // Pulse when the synchronized level goes from low to high.
            always_comb edge_o = ~prev_q & sync_q[TOP];
        end
    endgenerate
endmodule

// File: rtl/rtfifo_stage.sv
// Module: rtfifo_stage
// One FIFO position: a data register plus an occupancy marker.
// take_i fills the stage, give_i empties it, clear_i drops the marker
// without touching the data.
// Assumes: take_i only when empty, give_i only when full.
module rtfifo_stage #(
    parameter int unsigned WIDTH = rtfifo_pkg::RT_WIDTH
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear_i,
    input  logic             take_i,
    input  logic             give_i,
    input  logic [WIDTH-1:0] data_i,
    output logic             marker_o,
    output logic [WIDTH-1:0] data_o
);
    // Update occupancy; master clear wins over any transfer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            marker_o <= 1'b0;
        end else if (clear_i) begin
            marker_o <= 1'b0;
        end else begin
            marker_o <= take_i | (marker_o & ~give_i);
        end
    end

    // Capture the incoming word on a transfer; clear leaves data alone.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_o <= '0;
        end else if (take_i && !clear_i) begin
            data_o <= data_i;
        end
    end
endmodule

// File: rtl/rtfifo_top.sv
// Module: rtfifo_top
// Ripple-through FIFO built from a chain of marker-bit stages. Stage 0 is
// the input end and stage DEPTH-1 the output end. A vacant stage takes the
// word from a full upstream neighbour each clock.
// Assumes: din stable while shift_in is high; mreset synchronous to clk.
module rtfifo_top #(
    parameter int unsigned DEPTH       = rtfifo_pkg::RT_DEPTH,
    parameter int unsigned WIDTH       = rtfifo_pkg::RT_WIDTH,
    parameter int unsigned SYNC_STAGES = rtfifo_pkg::RT_SYNC_STAGES
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mreset,
    input  logic             shift_in,
    input  logic [WIDTH-1:0] din,
    output logic             in_ready,
    input  logic             shift_out,
    input  logic             out_disable,
    output logic [WIDTH-1:0] dout,
    output logic             out_valid,
    output logic             dout_en
);
    localparam int unsigned LAST = DEPTH - 1;

    logic             si_rise;
    logic             so_fall;
    logic             so_gated;
    logic             load_fire;
    logic             unload_fire;
    logic [DEPTH-1:0] marker_q;
    logic [DEPTH-1:0] take;
    logic [DEPTH-1:0] give;
    logic [WIDTH-1:0] word_q [DEPTH];

    // Disable high holds the effective strobe high; release while low = edge.
    always_comb so_gated = shift_out | out_disable;

    rtfifo_edge_sync #(
        .STAGES    (SYNC_STAGES),
        .FALLING   (1'b0),
        .RESET_VAL (1'b1)
    ) u_si_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .strobe_i (shift_in),
        .edge_o   (si_rise)
    );

    rtfifo_edge_sync #(
        .STAGES    (SYNC_STAGES),
        .FALLING   (1'b1),
        .RESET_VAL (1'b0)
    ) u_so_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .strobe_i (so_gated),
        .edge_o   (so_fall)
    );

    // Accept strobes only when the end stage allows it.
    always_comb begin
        load_fire   = si_rise & ~marker_q[0];
        unload_fire = so_fall & marker_q[LAST];
    end

    generate
        for (genvar i = 0; i < DEPTH; i++) begin : g_stage
            if (i == 0) begin : g_head
                // Input stage fills from the external load.
                always_comb take[i] = load_fire;
            end else begin : g_body
                // Vacant stage pulls from a full upstream neighbour.
                always_comb take[i] = marker_q[i-1] & ~marker_q[i];
            end

            if (i == LAST) begin : g_tail
                // Output stage empties on an accepted removal.
                always_comb give[i] = unload_fire;
            end else begin : g_pass
                // Other stages empty when the next stage takes their word.
                always_comb give[i] = take[i+1];
            end

            rtfifo_stage #(
                .WIDTH (WIDTH)
            ) u_stage (
                .clk      (clk),
                .rst_n    (rst_n),
                .clear_i  (mreset),
                .take_i   (take[i]),
                .give_i   (give[i]),
                .data_i   ((i == 0) ? din : word_q[(i == 0) ? 0 : i-1]),
                .marker_o (marker_q[i]),
                .data_o   (word_q[i])
            );
        end
    endgenerate

    // Flags and output bus come straight from the end stages.
    always_comb begin
        in_ready  = ~marker_q[0];
        out_valid = marker_q[LAST];
        dout      = word_q[LAST];
        dout_en   = ~out_disable;
    end
endmodule

// File: rtl/rtfifo_checker.sv
// Module: rtfifo_checker
// Temporal checks on the FIFO, bound into rtfifo_top.
// Assumes: sampled on the block clock, idle while rst_n is low.
module rtfifo_checker #(
    parameter int unsigned DEPTH = rtfifo_pkg::RT_DEPTH,
    parameter int unsigned WIDTH = rtfifo_pkg::RT_WIDTH
) (
    input logic             clk,
    input logic             rst_n,
    input logic             mreset,
    input logic             in_ready,
    input logic             out_valid,
    input logic [WIDTH-1:0] dout,
    input logic             load_fire,
    input logic             unload_fire,
    input logic [DEPTH-1:0] marker_q
);
    assert_mreset_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
        mreset |=> (in_ready && !out_valid));

    assert_load_blocks_input_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (load_fire && !mreset) |=> !in_ready);

    assert_output_held_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !unload_fire) |=> $stable(dout));

    assert_count_kept_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!mreset && !load_fire && !unload_fire)
        |=> ($countones(marker_q) == $past($countones(marker_q))));

    assert_both_honoured_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!mreset && load_fire && unload_fire)
        |=> ($countones(marker_q) == $past($countones(marker_q))));
endmodule

bind rtfifo_top rtfifo_checker #(
    .DEPTH (DEPTH),
    .WIDTH (WIDTH)
) u_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .mreset      (mreset),
    .in_ready    (in_ready),
    .out_valid   (out_valid),
    .dout        (dout),
    .load_fire   (load_fire),
    .unload_fire (unload_fire),
    .marker_q    (marker_q)
);

// File: tb/rtfifo_top_tb_top.sv
// Scoreboard bench: push_word records expected words, pop_word compares.
module rtfifo_top_tb_top;
    logic       clk = 1'b0;
    logic       rst_n;
    logic       mreset;
    logic       shift_in;
    logic [3:0] din;
    logic       in_ready;
    logic       shift_out;
    logic       out_disable;
    logic [3:0] dout;
    logic       out_valid;
    logic       dout_en;

    int n_cmp = 0;
    int n_bad = 0;
    logic [3:0] exp_q [$];
    logic [3:0] held;

    always #4ns clk = ~clk;

    rtfifo_top dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .mreset      (mreset),
        .shift_in    (shift_in),
        .din         (din),
        .in_ready    (in_ready),
        .shift_out   (shift_out),
        .out_disable (out_disable),
        .dout        (dout),
        .out_valid   (out_valid),
        .dout_en     (dout_en)
    );

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Driver: load one word and record it on the scoreboard.
    task automatic push_word(input logic [3:0] d);
        int waited = 0;
        while (!in_ready && waited < 100) begin
            tick(1);
            waited++;
        end
        check(in_ready == 1'b1, "R3 in_ready wait", int'(in_ready), 1);
        din      = d;
        shift_in = 1'b1;
        exp_q.push_back(d);
        tick(4);
        shift_in = 1'b0;
        tick(3);
    endtask

    // Monitor: wait for a word, compare with the scoreboard, remove it.
    task automatic pop_word(input string req);
        int waited = 0;
        while (!out_valid && waited < 100) begin
            tick(1);
            waited++;
        end
        if (exp_q.size() == 0) begin
            check(1'b0, req, int'(out_valid), 0);
        end else begin
            check(out_valid && dout == exp_q[0], req, int'(dout), int'(exp_q[0]));
            void'(exp_q.pop_front());
        end
        shift_out = 1'b0;
        tick(4);
        shift_out = 1'b1;
        tick(3);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        rst_n = 1'b0; mreset = 1'b0; shift_in = 1'b0; din = '0;
        shift_out = 1'b1; out_disable = 1'b0;
        tick(3);
        rst_n = 1'b1;
        tick(1);
        check(in_ready == 1'b1, "R1 in_ready", int'(in_ready), 1);
        check(out_valid == 1'b0, "R1 out_valid", int'(out_valid), 0);
        check(dout_en == 1'b1, "R1 dout_en", int'(dout_en), 1);

        // R4 latency, R3 input-ready dip, R2 held strobe
        din = 4'hA; shift_in = 1'b1; exp_q.push_back(4'hA);
        tick(3);
        check(in_ready == 1'b0, "R3 dip", int'(in_ready), 0);
        tick(1);
        check(in_ready == 1'b1, "R3 recover", int'(in_ready), 1);
        tick(13);
        check(out_valid == 1'b0, "R4 edge17", int'(out_valid), 0);
        tick(1);
        check(out_valid == 1'b1, "R4 edge18", int'(out_valid), 1);
        pop_word("R5 first word");
        tick(30);
        shift_in = 1'b0;
        tick(30);
        check(out_valid == 1'b0, "R2 single load", int'(out_valid), 0);

        // R6: removal on empty is ignored
        shift_out = 1'b0; tick(4); shift_out = 1'b1; tick(3);
        push_word(4'h5);
        tick(30);
        pop_word("R6 word after empty removal");
        tick(30);
        check(out_valid == 1'b0, "R6 empty after", int'(out_valid), 0);

        // R3 full, R5 order
        for (int i = 0; i < 16; i++) push_word(4'(i ^ 3));
        tick(30);
        check(in_ready == 1'b0, "R3 full", int'(in_ready), 0);
        din = 4'hF; shift_in = 1'b1; tick(4); shift_in = 1'b0; tick(3);
        for (int i = 0; i < 16; i++) pop_word("R5 drain order");
        tick(40);
        check(out_valid == 1'b0, "R3 extra ignored", int'(out_valid), 0);

        // R7 disable inhibits, R11 enable, R8 release removes
        push_word(4'h9);
        tick(30);
        out_disable = 1'b1;
        tick(1);
        check(dout_en == 1'b0, "R11 dout_en", int'(dout_en), 0);
        shift_out = 1'b0; tick(4); shift_out = 1'b1; tick(10);
        check(out_valid == 1'b1, "R7 valid kept", int'(out_valid), 1);
        check(dout == 4'h9, "R7 dout kept", int'(dout), 9);
        shift_out = 1'b0;
        tick(10);
        check(out_valid == 1'b1, "R7 low strobe", int'(out_valid), 1);
        out_disable = 1'b0;
        tick(5);
        check(out_valid == 1'b0, "R8 release removes", int'(out_valid), 0);
        void'(exp_q.pop_front());
        shift_out = 1'b1;
        tick(3);

        // R10 simultaneous load and removal
        for (int i = 1; i <= 4; i++) push_word(4'(i));
        tick(40);
        check(in_ready == 1'b1, "R10 in_ready", int'(in_ready), 1);
        check(out_valid && dout == exp_q[0], "R10 head", int'(dout), int'(exp_q[0]));
        void'(exp_q.pop_front());
        din = 4'h7; exp_q.push_back(4'h7);
        shift_in = 1'b1; shift_out = 1'b0;
        tick(4);
        shift_in = 1'b0; shift_out = 1'b1;
        tick(3);
        for (int i = 0; i < 4; i++) pop_word("R10 order");
        tick(40);
        check(out_valid == 1'b0, "R10 count", int'(out_valid), 0);

        // R9 master reset keeps data, clears occupancy
        push_word(4'hC); push_word(4'hD); push_word(4'hE);
        tick(40);
        held = dout;
        check(held == 4'hC, "R9 head before", int'(held), 12);
        mreset = 1'b1; tick(1); mreset = 1'b0; tick(1);
        check(in_ready == 1'b1, "R9 in_ready", int'(in_ready), 1);
        check(out_valid == 1'b0, "R9 out_valid", int'(out_valid), 0);
        check(dout == held, "R9 data kept", int'(dout), int'(held));
        exp_q.delete();
        push_word(4'h6);
        tick(30);
        pop_word("R9 load after reset");

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule